// File: doc/BRIEF.md
# Return Stack with Fast Context Restore

This block holds subroutine return addresses for a small 8-bit processor core. The call logic offers a return address on a push request. When that push is marked as a fast call, the current working register (W), STATUS and bank-select (BSR) values are captured into shadow copies on the same clock edge. A return instruction word pops the most recent address and hands it to the program counter. One bit of the return opcode chooses whether the shadow copies are also written back into W, STATUS and BSR.

A return occupies two instruction cycles. In the first cycle the controller recognises the return and pops the stack, moving from `ST_READY` to `ST_RET_SLOT` (transition "accept return"). In the second cycle it presents the new program counter with `pc_load` and, for a fast return, the restore write enables. This slot is a no-operation slot, so instructions and push requests that arrive during it are dropped. The controller then returns to `ST_READY` unconditionally (transition "slot done"). Popping an empty stack yields address zero and sets a sticky underflow flag. Pushing onto a full stack discards the push and sets a sticky overflow flag.

Top module: `ret_stack_top`

## Requirements
- R1: After reset, `pc_load`, `w_we`, `status_we`, `bsr_we`, `ovf_flag` and `unf_flag` are all 0, and the stack is empty.
- R2: A return starts only when `instr_valid` is 1 in `ST_READY` and `instr_word` is 16'h0012 (restore bit = 0) or 16'h0013 (restore bit = 1), the restore bit being bit 0. Any other word, or a return word with `instr_valid` at 0, starts no return and leaves the stack unchanged.
- R3: On the cycle after an accepted return, `pc_load` is 1 for exactly one cycle. In that cycle `pc_value` equals the most recently pushed address that is still on the stack (last in, first out), and that entry is removed.
- R4: When the restore bit is 1, `w_we`, `status_we` and `bsr_we` are all 1 in the `pc_load` cycle, and `w_out`, `status_out` and `bsr_out` carry the shadow copies.
- R5: When the restore bit is 0, `w_we`, `status_we` and `bsr_we` stay 0 throughout the return.
- R6: An accepted push with `push_fast` = 1 loads `w_in`, `status_in` and `bsr_in` into the shadow copies on its clock edge. A push with `push_fast` = 0 leaves the shadow copies unchanged.
- R7: During the `pc_load` cycle (`ST_RET_SLOT`), `instr_valid` and `push_req` are ignored: no second return starts and nothing is pushed.
- R8: A return on an empty stack gives `pc_value` = 0 and sets `unf_flag`.
- R9: A push while 31 entries are held is discarded and sets `ovf_flag`. The stored entries stay intact, and a discarded fast push does not load the shadow copies.
- R10: If an accepted return and `push_req` occur in the same `ST_READY` cycle, the return is executed and the push is discarded.
- R11: `ovf_flag` and `unf_flag` stay 1 once set and are cleared only by reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_valid | input | 1 | `instr_word` holds a decoded instruction this cycle |
| instr_word | input | 16 | Instruction word |
| push_req | input | 1 | Push a return address (call) |
| push_addr | input | 21 | Return address to push |
| push_fast | input | 1 | Call is fast: capture W/STATUS/BSR shadows |
| w_in | input | 8 | Live W value |
| status_in | input | 8 | Live STATUS value |
| bsr_in | input | 4 | Live BSR value |
| pc_load | output | 1 | Load `pc_value` into the program counter |
| pc_value | output | 21 | Popped return address |
| w_out | output | 8 | Shadow W value |
| w_we | output | 1 | Write `w_out` into W |
| status_out | output | 8 | Shadow STATUS value |
| status_we | output | 1 | Write `status_out` into STATUS |
| bsr_out | output | 4 | Shadow BSR value |
| bsr_we | output | 1 | Write `bsr_out` into BSR |
| ovf_flag | output | 1 | Sticky overflow flag |
| unf_flag | output | 1 | Sticky underflow flag |

## Verification
A wrong stack pointer shows up at the next `pc_load` as a return address that is off by one entry. It can also show up as a flag that rises one push or pop too early or too late. A controller left in the wrong state is visible one cycle after the return word, as a missing, doubled or stretched `pc_load` pulse. A shadow copy captured at the wrong moment is seen only at the next fast return, as wrong `w_out`, `status_out` or `bsr_out` values. For that reason, every sequence ends with returns that drain the stack and compare each popped value.

// File: rtl/rstk_pkg.sv
package rstk_pkg;
    localparam int INSTR_W = 16;
    // Return opcode without its restore bit (word >> 1)
    localparam logic [INSTR_W-2:0] RET_OPC_HI = 15'h0009;

    typedef enum logic [0:0] {
        ST_READY    = 1'b0,
        ST_RET_SLOT = 1'b1
    } rstk_state_e;
endpackage

// File: rtl/rstk_decode.sv
module rstk_decode
    import rstk_pkg::*;
(
    input  logic               instr_valid,
    input  logic [INSTR_W-1:0] instr_word,
    output logic               is_ret,
    output logic               ret_fast
);
    always_comb begin
        is_ret   = instr_valid && (instr_word[INSTR_W-1:1] == RET_OPC_HI);
        ret_fast = instr_word[0];
    end
endmodule

// File: rtl/rstk_lifo.sv
module rstk_lifo #(
    parameter int DEPTH = 31,
    parameter int AW    = 21
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_en,
    input  logic [AW-1:0] push_data,
    input  logic          pop_en,
    output logic          push_ok,
    output logic [AW-1:0] top_data,
    output logic          ovf,
    output logic          unf
);
    localparam int PTR_W = $clog2(DEPTH + 1);

    logic [PTR_W-1:0] ptr;
    logic [AW-1:0]    mem [DEPTH];
    logic             full;
    logic             empty;

    always_comb begin
        full     = (ptr == PTR_W'(DEPTH));
        empty    = (ptr == '0);
        push_ok  = push_en && !full && !pop_en;
        top_data = empty ? '0 : mem[ptr - PTR_W'(1)];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr <= '0;
            ovf <= 1'b0;
            unf <= 1'b0;
        end else if (pop_en) begin
            if (empty) unf <= 1'b1;
            else       ptr <= ptr - PTR_W'(1);
        end else if (push_en) begin
            if (full) ovf <= 1'b1;
            else      ptr <= ptr + PTR_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem[ptr] <= push_data;
    end
endmodule

// File: rtl/rstk_shadow.sv
module rstk_shadow #(
    parameter int DW = 8,
    parameter int BW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [DW-1:0] w_in,
    input  logic [DW-1:0] status_in,
    input  logic [BW-1:0] bsr_in,
    output logic [DW-1:0] w_sh,
    output logic [DW-1:0] status_sh,
    output logic [BW-1:0] bsr_sh
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            w_sh      <= '0;
            status_sh <= '0;
            bsr_sh    <= '0;
        end else if (load) begin
            w_sh      <= w_in;
            status_sh <= status_in;
            bsr_sh    <= bsr_in;
        end
    end
endmodule

// File: rtl/rstk_ctrl.sv
module rstk_ctrl
    import rstk_pkg::*;
#(
    parameter int AW = 21
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ret_req,
    input  logic          ret_fast,
    input  logic [AW-1:0] top_data,
    output logic          ready,
    output logic          pop_en,
    output logic          pc_load,
    output logic [AW-1:0] pc_value,
    output logic          restore_en
);
    rstk_state_e state, state_nx;
    logic [AW-1:0] pc_hold;
    logic          fast_hold;

    // State register and return data captured at the pop edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_READY;
            pc_hold   <= '0;
            fast_hold <= 1'b0;
        end else begin
            state <= state_nx;
            if (pop_en) begin
                pc_hold   <= top_data;
                fast_hold <= ret_fast;
            end
        end
    end

    // Next state and outputs
    always_comb begin
        state_nx   = state;
        ready      = 1'b0;
        pop_en     = 1'b0;
        pc_load    = 1'b0;
        restore_en = 1'b0;
        pc_value   = pc_hold;
        unique case (state)
            ST_READY: begin
                ready  = 1'b1;
                pop_en = ret_req;
                if (ret_req) state_nx = ST_RET_SLOT;   // accept return
            end
            ST_RET_SLOT: begin
                pc_load    = 1'b1;
                restore_en = fast_hold;
                state_nx   = ST_READY;                 // slot done
            end
            default: state_nx = ST_READY;
        endcase
    end
endmodule

// File: rtl/ret_stack_top.sv
module ret_stack_top
    import rstk_pkg::*;
#(
    parameter int DEPTH = 31,
    parameter int AW    = 21,
    parameter int DW    = 8,
    parameter int BW    = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               instr_valid,
    input  logic [INSTR_W-1:0] instr_word,
    input  logic               push_req,
    input  logic [AW-1:0]      push_addr,
    input  logic               push_fast,
    input  logic [DW-1:0]      w_in,
    input  logic [DW-1:0]      status_in,
    input  logic [BW-1:0]      bsr_in,
    output logic               pc_load,
    output logic [AW-1:0]      pc_value,
    output logic [DW-1:0]      w_out,
    output logic               w_we,
    output logic [DW-1:0]      status_out,
    output logic               status_we,
    output logic [BW-1:0]      bsr_out,
    output logic               bsr_we,
    output logic               ovf_flag,
    output logic               unf_flag
);
    logic          is_ret, ret_fast, ready, pop_en, push_en, push_ok, restore_en;
    logic [AW-1:0] top_data;

    rstk_decode u_dec (
        .instr_valid (instr_valid),
        .instr_word  (instr_word),
        .is_ret      (is_ret),
        .ret_fast    (ret_fast)
    );

    rstk_ctrl #(.AW(AW)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .ret_req    (is_ret),
        .ret_fast   (ret_fast),
        .top_data   (top_data),
        .ready      (ready),
        .pop_en     (pop_en),
        .pc_load    (pc_load),
        .pc_value   (pc_value),
        .restore_en (restore_en)
    );

    assign push_en = push_req && ready;

    rstk_lifo #(.DEPTH(DEPTH), .AW(AW)) u_lifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_en   (push_en),
        .push_data (push_addr),
        .pop_en    (pop_en),
        .push_ok   (push_ok),
        .top_data  (top_data),
        .ovf       (ovf_flag),
        .unf       (unf_flag)
    );

    rstk_shadow #(.DW(DW), .BW(BW)) u_shadow (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (push_ok && push_fast),
        .w_in      (w_in),
        .status_in (status_in),
        .bsr_in    (bsr_in),
        .w_sh      (w_out),
        .status_sh (status_out),
        .bsr_sh    (bsr_out)
    );

    always_comb begin
        w_we      = restore_en;
        status_we = restore_en;
        bsr_we    = restore_en;
    end
endmodule

// File: rtl/rstk_checker.sv
module rstk_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        instr_valid,
    input logic [15:0] instr_word,
    input logic        pc_load,
    input logic        w_we,
    input logic        status_we,
    input logic        bsr_we,
    input logic        ovf_flag,
    input logic        unf_flag
);
    assert_origin_R2: assert property (@(posedge clk) disable iff (!rst_n)
        pc_load |-> $past(instr_valid && (instr_word[15:1] == 15'h0009)));

    assert_one_slot_R3: assert property (@(posedge clk) disable iff (!rst_n)
        pc_load |=> !pc_load);

    assert_restore_R4: assert property (@(posedge clk) disable iff (!rst_n)
        w_we |-> (pc_load && $past(instr_word[0])));

    assert_group_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (w_we == status_we) && (w_we == bsr_we));

    assert_no_restore_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_load && !$past(instr_word[0])) |-> !(w_we || status_we || bsr_we));

    assert_ovf_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_flag |=> ovf_flag);

    assert_unf_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        unf_flag |=> unf_flag);
endmodule

bind ret_stack_top rstk_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .instr_valid (instr_valid),
    .instr_word  (instr_word),
    .pc_load     (pc_load),
    .w_we        (w_we),
    .status_we   (status_we),
    .bsr_we      (bsr_we),
    .ovf_flag    (ovf_flag),
    .unf_flag    (unf_flag)
);

// File: tb/ret_stack_top_test.sv
module ret_stack_top_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        instr_valid = 1'b0;
    logic [15:0] instr_word = '0;
    logic        push_req = 1'b0;
    logic [20:0] push_addr = '0;
    logic        push_fast = 1'b0;
    logic [7:0]  w_in = '0;
    logic [7:0]  status_in = '0;
    logic [3:0]  bsr_in = '0;
    logic        pc_load, w_we, status_we, bsr_we, ovf_flag, unf_flag;
    logic [20:0] pc_value;
    logic [7:0]  w_out, status_out;
    logic [3:0]  bsr_out;

    int n_tests = 0;
    int n_fail  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ret_stack_top uut (
        .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr_word(instr_word),
        .push_req(push_req), .push_addr(push_addr), .push_fast(push_fast),
        .w_in(w_in), .status_in(status_in), .bsr_in(bsr_in),
        .pc_load(pc_load), .pc_value(pc_value), .w_out(w_out), .w_we(w_we),
        .status_out(status_out), .status_we(status_we), .bsr_out(bsr_out),
        .bsr_we(bsr_we), .ovf_flag(ovf_flag), .unf_flag(unf_flag)
    );

    // {is_ret, fast, addr[20:0], w[7:0], exp_pc[20:0], exp_w[7:0]}
    localparam logic [59:0] VEC [8] = '{
        {1'b0, 1'b0, 21'h00100, 8'h00, 21'h0,     8'h00},
        {1'b0, 1'b1, 21'h00200, 8'h11, 21'h0,     8'h00},
        {1'b0, 1'b0, 21'h1ABCD, 8'h22, 21'h0,     8'h00},
        {1'b1, 1'b1, 21'h0,     8'h00, 21'h1ABCD, 8'h11},
        {1'b0, 1'b1, 21'h00300, 8'h33, 21'h0,     8'h00},
        {1'b1, 1'b0, 21'h0,     8'h00, 21'h00300, 8'h00},
        {1'b1, 1'b1, 21'h0,     8'h00, 21'h00200, 8'h33},
        {1'b1, 1'b0, 21'h0,     8'h00, 21'h00100, 8'h00}
    };

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_push(input logic [20:0] a, input logic f, input logic [7:0] w);
        push_req = 1'b1; push_addr = a; push_fast = f;
        w_in = w; status_in = w ^ 8'hA5; bsr_in = w[3:0];
        @(posedge clk); @(negedge clk);
        push_req = 1'b0; push_fast = 1'b0;
    endtask

    // Issue a return, check the pc_load cycle and the cycle after it
    task automatic do_ret(input logic s, input logic [20:0] exp_pc, input logic [7:0] exp_w,
                          input string req);
        instr_valid = 1'b1; instr_word = {15'h0009, s};
        @(posedge clk); @(negedge clk);
        instr_valid = 1'b0;
        check(pc_load == 1'b1, {req, " R3 pc_load"}, 32'(pc_load), 1);
        check(pc_value == exp_pc, {req, " R3 pc_value"}, 32'(pc_value), 32'(exp_pc));
        if (s) begin
            check(w_we && status_we && bsr_we, {req, " R4 write enables"},
                  {29'd0, w_we, status_we, bsr_we}, 7);
            check(w_out == exp_w, {req, " R4 w_out"}, 32'(w_out), 32'(exp_w));
            check(status_out == (exp_w ^ 8'hA5), {req, " R4 status_out"},
                  32'(status_out), 32'(exp_w ^ 8'hA5));
            check(bsr_out == exp_w[3:0], {req, " R4 bsr_out"}, 32'(bsr_out), 32'(exp_w[3:0]));
        end else begin
            check(!(w_we || status_we || bsr_we), {req, " R5 no restore"},
                  {29'd0, w_we, status_we, bsr_we}, 0);
        end
        @(posedge clk); @(negedge clk);
        check(pc_load == 1'b0, {req, " R3 single pulse"}, 32'(pc_load), 0);
    endtask

    initial begin : watchdog
        repeat (50000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(!pc_load && !w_we && !status_we && !bsr_we, "R1 outputs idle",
              {28'd0, pc_load, w_we, status_we, bsr_we}, 0);
        check(!ovf_flag && !unf_flag, "R1 flags clear", {30'd0, ovf_flag, unf_flag}, 0);

        // Table walk: R3 LIFO order, R4/R5 restore, R6 shadow load rules
        for (int i = 0; i < 8; i++) begin
            if (VEC[i][59])
                do_ret(VEC[i][58], VEC[i][28:8], VEC[i][7:0], $sformatf("vec%0d R6", i));
            else
                do_push(VEC[i][57:37], VEC[i][58], VEC[i][36:29]);
        end

        // R2: non-return words and invalid return word start nothing
        do_push(21'h0ABCD, 1'b0, 8'h00);
        foreach (instr_word[k]) begin end
        instr_valid = 1'b1; instr_word = 16'h0014;
        @(posedge clk); @(negedge clk);
        check(!pc_load, "R2 word 0014", 32'(pc_load), 0);
        instr_word = 16'h8013;
        @(posedge clk); @(negedge clk);
        check(!pc_load, "R2 word 8013", 32'(pc_load), 0);
        instr_valid = 1'b0; instr_word = 16'h0013;
        @(posedge clk); @(negedge clk);
        check(!pc_load, "R2 invalid return", 32'(pc_load), 0);
        @(posedge clk); @(negedge clk);
        check(!pc_load, "R2 no late pulse", 32'(pc_load), 0);
        do_ret(1'b0, 21'h0ABCD, 8'h00, "R2 stack kept");

        // R7: inputs during the return slot are ignored
        do_push(21'h00011, 1'b0, 8'h00);
        do_push(21'h00022, 1'b0, 8'h00);
        instr_valid = 1'b1; instr_word = 16'h0012;
        @(posedge clk); @(negedge clk);
        check(pc_load && pc_value == 21'h00022, "R7 first return", 32'(pc_value), 32'h22);
        push_req = 1'b1; push_addr = 21'h00033; push_fast = 1'b1; w_in = 8'h99;
        @(posedge clk); @(negedge clk);
        instr_valid = 1'b0; push_req = 1'b0; push_fast = 1'b0;
        check(!pc_load, "R7 no second return", 32'(pc_load), 0);
        do_ret(1'b1, 21'h00011, 8'h33, "R7 push dropped");

        // R10: simultaneous return and push
        do_push(21'h00044, 1'b0, 8'h00);
        push_req = 1'b1; push_addr = 21'h00055;
        do_ret(1'b0, 21'h00044, 8'h00, "R10 return wins");
        push_req = 1'b0;

        // R8: underflow
        check(!unf_flag, "R8 before underflow", 32'(unf_flag), 0);
        do_ret(1'b0, 21'h0, 8'h00, "R8 empty pop");
        check(unf_flag, "R8 underflow set", 32'(unf_flag), 1);

        // R9: overflow
        for (int i = 0; i < 31; i++) do_push(21'(i + 1), 1'b0, 8'h00);
        check(!ovf_flag, "R9 full no overflow", 32'(ovf_flag), 0);
        do_push(21'h1FFFF, 1'b1, 8'h77);
        check(ovf_flag, "R9 overflow set", 32'(ovf_flag), 1);
        do_ret(1'b1, 21'd31, 8'h33, "R9 top intact no shadow");
        for (int i = 30; i >= 1; i--) do_ret(1'b0, 21'(i), 8'h00, "R9 drain");
        check(ovf_flag && unf_flag, "R11 flags sticky", {30'd0, ovf_flag, unf_flag}, 3);

        // R11: reset clears flags
        rst_n = 1'b0;
        @(posedge clk); @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!ovf_flag && !unf_flag, "R11 cleared by reset", {30'd0, ovf_flag, unf_flag}, 0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule